// File: doc/BRIEF.md
# Fault Management Controller

This block watches a vector of system event lines, for instance uncorrectable memory errors or peripheral status flags, and decides per source what each event means. A source enabled for interrupts drives a registered interrupt request toward the processor. A source enabled as a fault records itself in a sticky status register and starts the fault sequence. A source may be enabled for both.

A fault does not act at once. A programmable cycle count runs down first. When it reaches zero the controller takes the selected action. The action is either holding an external fault pin high until software clears it, or a single-cycle request for a full device reset. While the count runs, software can cancel the action by writing two fixed key values in a row to a key register. After a cancel the controller waits until every enabled fault status bit has been cleared and then returns to idle.

Software reaches the block through a simple write port and a combinational read port, both with a 3-bit register address. The register addresses are: 0 interrupt enable mask, 1 fault enable mask, 2 sticky fault status (write one to clear), 3 control (bit 0: 1 selects device reset, 0 selects the fault pin), 4 delay count, 5 key, 6 pin clear (write bit 0 = 1), 7 controller state (read only: 0 idle, 1 pending, 2 active, 3 cancelled).

Top module: `fault_mgr`

## Requirements
- R1: On the clock edge that samples the inputs, `irq_o` becomes the OR of (event inputs AND interrupt enable mask). It is low when no enabled source is active.
- R2: Each status bit is set on any edge where its event is high and its fault enable bit is 1. It then holds until a write to address 2 with a 1 in that bit position. A set on the same edge takes priority over the clear.
- R3: An event whose fault enable bit is 0 sets no status bit and leaves the controller idle, even while the event is held high.
- R4: An enabled fault sampled in idle moves the controller to pending with the delay value D loaded. The action is taken on the edge D+1 cycles later, and the state reads 2 from that edge on.
- R5: In pin mode `fault_pin_o` goes high with the action. It stays high until a write of 1 in bit 0 to address 6. That write lowers the pin and returns the controller to idle on the same edge.
- R6: In reset mode `rst_req_o` is high for exactly one cycle and `fault_pin_o` stays low. The controller is idle on the next edge.
- R7: Writing the first key value and then the second key value in consecutive key-register writes, while pending, moves the controller to cancelled. No action is taken afterwards.
- R8: A key write of any other value between the two keys, or the second key on its own, cancels nothing. The action then fires on schedule.
- R9: In the cancelled state the controller returns to idle on the edge after (status AND fault enable) becomes zero.
- R10: After reset all registers, `irq_o`, `fault_pin_o` and `rst_req_o` are zero and the state is idle.
- R11: Further fault events while pending update status only. They do not restart or change the countdown.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| evt_i | input | N_SRC | System event lines, active high |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Write register address |
| wr_data | input | DW | Write data |
| rd_addr | input | 3 | Read register address |
| rd_data | output | DW | Read data, combinational from rd_addr |
| irq_o | output | 1 | Interrupt request to the processor |
| fault_pin_o | output | 1 | External fault indication |
| rst_req_o | output | 1 | Single-cycle device reset request |

## Verification
The hardest situation to reach is a cancel or a status clear that races live traffic: the second key arriving one write after a wrong value, or a write-one-to-clear landing on the same edge as a new event. The stimulus holds the controller in a long pending window and then walks every clear mask against a shifted event pattern on the same cycle. It also drives the wrong-key and lone-second-key sequences inside that window. A short-delay sweep places a second fault in the middle of the countdown to confirm that the deadline does not move.

// File: rtl/fm_pkg.sv
package fm_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_PEND = 2'd1,
    ST_ACT  = 2'd2,
    ST_CANC = 2'd3
  } fm_state_t;

  localparam logic [2:0] A_IRQEN = 3'd0;
  localparam logic [2:0] A_FLTEN = 3'd1;
  localparam logic [2:0] A_STAT  = 3'd2;
  localparam logic [2:0] A_CTL   = 3'd3;
  localparam logic [2:0] A_DLY   = 3'd4;
  localparam logic [2:0] A_KEY   = 3'd5;
  localparam logic [2:0] A_PCLR  = 3'd6;
  localparam logic [2:0] A_STATE = 3'd7;
endpackage

// File: rtl/fm_regs.sv
module fm_regs
  import fm_pkg::*;
#(
  parameter int N_SRC = 8,
  parameter int DW    = 16,
  parameter int DLY_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_SRC-1:0] evt_i,
  input  logic             wr_en,
  input  logic [2:0]       wr_addr,
  input  logic [DW-1:0]    wr_data,
  output logic [N_SRC-1:0] irq_en_q,
  output logic [N_SRC-1:0] flt_en_q,
  output logic [N_SRC-1:0] status_q,
  output logic             act_rst_q,
  output logic [DLY_W-1:0] dly_q,
  output logic             hit,
  output logic             pclr_stb,
  output logic             key_stb
);
  logic             we_irq, we_flt, we_stat, we_ctl, we_dly;
  logic [N_SRC-1:0] w1c_mask, status_d;
  logic             unused_hi;

  assign unused_hi = ^wr_data;

  always_comb begin
    we_irq   = wr_en && (wr_addr == A_IRQEN);
    we_flt   = wr_en && (wr_addr == A_FLTEN);
    we_stat  = wr_en && (wr_addr == A_STAT);
    we_ctl   = wr_en && (wr_addr == A_CTL);
    we_dly   = wr_en && (wr_addr == A_DLY);
    key_stb  = wr_en && (wr_addr == A_KEY);
    pclr_stb = wr_en && (wr_addr == A_PCLR) && wr_data[0];
    w1c_mask = we_stat ? wr_data[N_SRC-1:0] : '0;
    status_d = (status_q & ~w1c_mask) | (evt_i & flt_en_q);
    hit      = |(evt_i & flt_en_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_en_q  <= '0;
      flt_en_q  <= '0;
      status_q  <= '0;
      act_rst_q <= 1'b0;
      dly_q     <= '0;
    end else begin
      if (we_irq) irq_en_q  <= wr_data[N_SRC-1:0];
      if (we_flt) flt_en_q  <= wr_data[N_SRC-1:0];
      if (we_ctl) act_rst_q <= wr_data[0];
      if (we_dly) dly_q     <= wr_data[DLY_W-1:0];
      status_q <= status_d;
    end
  end
endmodule

// File: rtl/fm_key.sv
module fm_key #(
  parameter int          DW    = 16,
  parameter logic [15:0] KEY_A = 16'h5A17,
  parameter logic [15:0] KEY_B = 16'hC3E9
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          key_stb,
  input  logic [DW-1:0] key_data,
  output logic          cancel
);
  logic armed_q, armed_d;

  always_comb begin
    armed_d = armed_q;
    cancel  = 1'b0;
    if (key_stb) begin
      cancel  = armed_q && (key_data == DW'(KEY_B));
      armed_d = (key_data == DW'(KEY_A));
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) armed_q <= 1'b0;
    else        armed_q <= armed_d;
  end
endmodule

// File: rtl/fm_seq.sv
module fm_seq
  import fm_pkg::*;
#(
  parameter int DLY_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             trig,
  input  logic             cancel,
  input  logic             pclr,
  input  logic             act_rst,
  input  logic             pend_src,
  input  logic [DLY_W-1:0] dly,
  output fm_state_t        state_q,
  output logic             fault_pin_q,
  output logic             rst_req_q
);
  fm_state_t        state_d;
  logic [DLY_W-1:0] cnt_q, cnt_d;
  logic             pin_d, rst_d;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    pin_d   = fault_pin_q;
    rst_d   = 1'b0;
    unique case (state_q)
      ST_IDLE: if (trig) begin
        state_d = ST_PEND;
        cnt_d   = dly;
      end
      ST_PEND: begin
        if (cancel) begin
          state_d = ST_CANC;
        end else if (cnt_q == '0) begin
          state_d = ST_ACT;
          if (act_rst) rst_d = 1'b1;
          else         pin_d = 1'b1;
        end else begin
          cnt_d = cnt_q - 1'b1;
        end
      end
      ST_ACT: begin
        if (act_rst) begin
          state_d = ST_IDLE;
        end else if (pclr) begin
          pin_d   = 1'b0;
          state_d = ST_IDLE;
        end
      end
      ST_CANC: if (!pend_src) state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q     <= ST_IDLE;
      cnt_q       <= '0;
      fault_pin_q <= 1'b0;
      rst_req_q   <= 1'b0;
    end else begin
      state_q     <= state_d;
      cnt_q       <= cnt_d;
      fault_pin_q <= pin_d;
      rst_req_q   <= rst_d;
    end
  end
endmodule

// File: rtl/fault_mgr.sv
module fault_mgr
  import fm_pkg::*;
#(
  parameter int          N_SRC = 8,
  parameter int          DW    = 16,
  parameter int          DLY_W = 16,
  parameter logic [15:0] KEY_A = 16'h5A17,
  parameter logic [15:0] KEY_B = 16'hC3E9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_SRC-1:0] evt_i,
  input  logic             wr_en,
  input  logic [2:0]       wr_addr,
  input  logic [DW-1:0]    wr_data,
  input  logic [2:0]       rd_addr,
  output logic [DW-1:0]    rd_data,
  output logic             irq_o,
  output logic             fault_pin_o,
  output logic             rst_req_o
);
  logic [1:0]       rst_sync_q;
  logic             rst_ns;
  logic [N_SRC-1:0] irq_en_q, flt_en_q, status_q;
  logic             act_rst_q, hit, pclr_stb, key_stb, cancel, irq_q;
  logic [DLY_W-1:0] dly_q;
  fm_state_t        fsm_state;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_ns = rst_sync_q[1];

  fm_regs #(.N_SRC(N_SRC), .DW(DW), .DLY_W(DLY_W)) u_regs (
    .clk(clk), .rst_n(rst_ns), .evt_i(evt_i), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .irq_en_q(irq_en_q),
    .flt_en_q(flt_en_q), .status_q(status_q), .act_rst_q(act_rst_q),
    .dly_q(dly_q), .hit(hit), .pclr_stb(pclr_stb), .key_stb(key_stb)
  );

  fm_key #(.DW(DW), .KEY_A(KEY_A), .KEY_B(KEY_B)) u_key (
    .clk(clk), .rst_n(rst_ns), .key_stb(key_stb), .key_data(wr_data),
    .cancel(cancel)
  );

  fm_seq #(.DLY_W(DLY_W)) u_seq (
    .clk(clk), .rst_n(rst_ns), .trig(hit), .cancel(cancel),
    .pclr(pclr_stb), .act_rst(act_rst_q),
    .pend_src(|(status_q & flt_en_q)), .dly(dly_q),
    .state_q(fsm_state), .fault_pin_q(fault_pin_o), .rst_req_q(rst_req_o)
  );

  always_ff @(posedge clk or negedge rst_ns) begin
    if (!rst_ns) irq_q <= 1'b0;
    else         irq_q <= |(evt_i & irq_en_q);
  end
  assign irq_o = irq_q;

  always_comb begin
    unique case (rd_addr)
      A_IRQEN: rd_data = DW'(irq_en_q);
      A_FLTEN: rd_data = DW'(flt_en_q);
      A_STAT:  rd_data = DW'(status_q);
      A_CTL:   rd_data = DW'(act_rst_q);
      A_DLY:   rd_data = DW'(dly_q);
      A_STATE: rd_data = DW'(fsm_state);
      default: rd_data = '0;
    endcase
  end
endmodule

// File: rtl/fm_checker.sv
module fm_checker
  import fm_pkg::*;
#(
  parameter int N_SRC = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             wr_en,
  input logic [2:0]       wr_addr,
  input logic             wr_bit0,
  input fm_state_t        state,
  input logic             fault_pin,
  input logic             rst_req,
  input logic [N_SRC-1:0] status,
  input logic [N_SRC-1:0] flt_en
);
  // R6: reset request lasts a single cycle
  a_r6_rst_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |=> !rst_req);

  // R4: an action only appears once the controller is active
  a_r4_action_in_active: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |-> (state == ST_ACT));

  // R5: pin holds until an explicit clear write
  a_r5_pin_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (fault_pin && !(wr_en && wr_addr == A_PCLR && wr_bit0)) |=> fault_pin);

  // R7: a cancelled fault never produces an action
  a_r7_cancel_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_CANC) |-> (!fault_pin && !rst_req));

  // R2: status bits only fall on a status write
  a_r2_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && wr_addr == A_STAT) |=> ((status & $past(status)) == $past(status)));

  // R9: cancelled with no enabled status pending leads to idle
  a_r9_leave_cancel: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_CANC && (status & flt_en) == '0) |=> (state == ST_IDLE));
endmodule

bind fault_mgr fm_checker #(.N_SRC(N_SRC)) u_chk (
  .clk(clk), .rst_n(rst_ns), .wr_en(wr_en), .wr_addr(wr_addr),
  .wr_bit0(wr_data[0]), .state(fsm_state), .fault_pin(fault_pin_o),
  .rst_req(rst_req_o), .status(status_q), .flt_en(flt_en_q)
);

// File: tb/sim_fault_mgr.sv
module sim_fault_mgr;
  localparam int CLK_P = 10;
  localparam int NS = 4;
  localparam int DW = 16;
  localparam logic [15:0] KA = 16'h5A17;
  localparam logic [15:0] KB = 16'hC3E9;

  logic clk, rst_n, wr_en, irq_o, fault_pin_o, rst_req_o;
  logic [NS-1:0] evt_i;
  logic [2:0] wr_addr, rd_addr;
  logic [DW-1:0] wr_data, rd_data;
  int checks, errors, cycles;

  fault_mgr #(.N_SRC(NS), .DW(DW), .DLY_W(8), .KEY_A(KA), .KEY_B(KB)) u0 (
    .clk(clk), .rst_n(rst_n), .evt_i(evt_i), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data), .irq_o(irq_o),
    .fault_pin_o(fault_pin_o), .rst_req_o(rst_req_o)
  );

  initial clk = 1'b0;
  always #(CLK_P/2) clk = ~clk;

  initial begin
    cycles = 0;
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 20000) begin
        errors++;
        $display("FAIL watchdog: actual %0d cycles expected < 20000", cycles);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
      end
    end
  end

  task automatic cyc();
    @(posedge clk); #1;
  endtask

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(logic [2:0] a, logic [DW-1:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    cyc();
    wr_en = 1'b0;
  endtask

  task automatic rd(logic [2:0] a, output logic [DW-1:0] v);
    rd_addr = a; #1; v = rd_data;
  endtask

  task automatic fire(logic [NS-1:0] p);
    evt_i = p; cyc(); evt_i = '0;
  endtask

  initial begin
    logic [DW-1:0] v;
    logic [NS-1:0] exp_st;
    checks = 0; errors = 0;
    rst_n = 1'b0; evt_i = '0; wr_en = 1'b0; wr_addr = '0; wr_data = '0; rd_addr = '0;
    repeat (3) cyc();
    // R10 reset state
    chk("R10 irq", irq_o, 0); chk("R10 pin", fault_pin_o, 0); chk("R10 rst", rst_req_o, 0);
    rd(3'd7, v); chk("R10 state", v, 0);
    rd(3'd2, v); chk("R10 status", v, 0);
    rst_n = 1'b1;
    repeat (4) cyc();

    // R1 sweep of masks and event patterns
    for (int m = 0; m < 16; m++) begin
      wr(3'd0, DW'(m));
      for (int e = 0; e < 16; e++) begin
        evt_i = NS'(e); cyc();
        chk("R1 irq", irq_o, 32'(|(m & e)));
      end
      evt_i = '0;
    end
    wr(3'd0, '0);

    // R3 disabled sources ignored
    wr(3'd1, 16'h1);
    evt_i = 4'b1110; repeat (5) cyc(); evt_i = '0;
    rd(3'd2, v); chk("R3 status", v, 0);
    rd(3'd7, v); chk("R3 state", v, 0);
    chk("R3 pin", fault_pin_o, 0);

    // R4 R5 R11 delay sweep, pin mode
    wr(3'd3, 16'h0); wr(3'd1, 16'hF);
    for (int di = 0; di < 4; di++) begin
      int d;
      d = (1 << di) - 1;
      wr(3'd4, DW'(d));
      fire(4'b0001);
      rd(3'd7, v); chk("R4 pending", v, 1);
      for (int k = 0; k < d; k++) begin
        if (k == 0) evt_i = 4'b0100;
        cyc(); evt_i = '0;
        chk("R4 early pin", fault_pin_o, 0);
        rd(3'd7, v); chk("R11 still pending", v, 1);
      end
      cyc();
      chk("R4 pin on time", fault_pin_o, 1);
      rd(3'd7, v); chk("R4 active", v, 2);
      rd(3'd2, v); chk("R11 status", v, (d > 0) ? 32'h5 : 32'h1);
      repeat (3) cyc();
      chk("R5 pin held", fault_pin_o, 1);
      wr(3'd6, 16'h1);
      chk("R5 pin cleared", fault_pin_o, 0);
      rd(3'd7, v); chk("R5 idle", v, 0);
      wr(3'd2, 16'hF);
    end

    // R6 reset mode
    wr(3'd3, 16'h1); wr(3'd4, 16'd2);
    fire(4'b1000);
    repeat (2) begin cyc(); chk("R6 early rst", rst_req_o, 0); end
    cyc();
    chk("R6 rst pulse", rst_req_o, 1); chk("R6 pin low", fault_pin_o, 0);
    cyc();
    chk("R6 rst drop", rst_req_o, 0);
    rd(3'd7, v); chk("R6 idle", v, 0);
    wr(3'd2, 16'hF);

    // R7 R9 cancel
    wr(3'd3, 16'h0); wr(3'd4, 16'd50);
    fire(4'b0010);
    wr(3'd5, KA); wr(3'd5, KB);
    rd(3'd7, v); chk("R7 cancelled", v, 3);
    repeat (60) cyc();
    chk("R7 no pin", fault_pin_o, 0); chk("R7 no rst", rst_req_o, 0);
    rd(3'd7, v); chk("R9 hold cancelled", v, 3);
    wr(3'd2, 16'hF);
    rd(3'd7, v); chk("R9 cancelled at clear", v, 3);
    cyc();
    rd(3'd7, v); chk("R9 idle", v, 0);

    // R8 broken key sequences
    wr(3'd4, 16'd30);
    fire(4'b0001);
    wr(3'd5, KA); wr(3'd5, 16'h1234); wr(3'd5, KB);
    rd(3'd7, v); chk("R8 wrong key", v, 1);
    wr(3'd5, KB);
    rd(3'd7, v); chk("R8 lone key", v, 1);
    repeat (30) cyc();
    chk("R8 pin fires", fault_pin_o, 1);
    wr(3'd6, 16'h1); wr(3'd2, 16'hF);

    // R2 sticky set and same-edge set/clear sweep
    wr(3'd4, 16'd200);
    exp_st = '0;
    for (int p = 1; p < 16; p += 3) begin
      fire(NS'(p)); exp_st |= NS'(p);
      rd(3'd2, v); chk("R2 accumulate", v, 32'(exp_st));
    end
    for (int m = 0; m < 16; m++) begin
      logic [NS-1:0] r;
      r = NS'(m) ^ 4'h5;
      evt_i = r; wr(3'd2, DW'(m)); evt_i = '0;
      exp_st = (exp_st & ~NS'(m)) | r;
      rd(3'd2, v); chk("R2 w1c", v, 32'(exp_st));
    end
    wr(3'd5, KA); wr(3'd5, KB);
    wr(3'd2, 16'hF); cyc();
    rd(3'd7, v); chk("R9 final idle", v, 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule